// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises an operand to a stored power and reduces the result by a stored modulus, giving y = x^e mod n. It suits a small public-key encryption step in which the modulus and exponent are set up once and then many data words are encrypted with them. A single command port carries a 2-bit command code and a data word. The same port starts an encryption and loads either of the two key registers.

The engine keeps its work simple. It performs e - 1 multiplications, counted down one at a time. After each product it reduces the running value by subtracting n once per cycle until the value falls below n. The operand is reduced modulo n before the first multiply. Because of that, both factors of every product are below n and the product always fits in a double-width register.

While a job runs, the engine ignores the command port. When the result is ready it publishes it and raises a done flag. That flag stays high until the next command is accepted. An encryption request made while either key register holds zero is refused with an error flag, and no computation takes place.

Top module: `modexp_engine`

## Requirements
- R1: After reset, result is 0, done and error are low, and both key registers hold 0, so an encryption issued straight after reset is refused with error.
- R2: The command code is sampled only while idle. Code 2'd2 loads the modulus from dataIn. Code 2'd3 loads the exponent from dataIn. Code 2'd0 changes nothing.
- R3: Code 2'd1 captures dataIn as x and computes x^e mod n. The engine then drives result and raises done, and both hold until the next accepted command.
- R4: x is reduced modulo n before any multiplication, so with e = 1 the result is x mod n, including for x >= n.
- R5: With n = 1 the result is 0 for any x and e.
- R6: A code 2'd1 request while n = 0 or e = 0 sets error high and done low, and leaves result unchanged. The flags done and error are never high together.
- R7: Commands presented while a job runs are ignored. A modulus or exponent load issued mid-job does not alter the key registers or the running job's result.
- R8: Every published result is below n. The running value is below n at each multiply, so the double-width product cannot overflow.
- R9: The key registers persist across jobs. Several encryptions in a row reuse the same n and e without reloading.
- R10: Any accepted command (codes 1, 2 or 3 with valid keys for code 1) clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdType | input | 2 | Command code: 0 none, 1 encrypt, 2 load modulus, 3 load exponent |
| dataIn | input | W | Operand or key value for the command |
| result | output | W | Last published x^e mod n |
| done | output | 1 | High from result publication until the next accepted command |
| error | output | 1 | High after an encryption refused for a zero key |

## Verification
The bench targets the following corner cases and what a faulty design would do in each:

- **e = 1:** the multiply loop runs zero times. A design that skipped the base reduction would return x itself, unreduced.
- **n = 1:** the result must be 0. A reduction that stopped at "not above n" rather than "below n" would return 1.
- **Zero key:** a design that missed the zero-key guard would hang in its subtract loop or publish garbage instead of raising error.
- **Mid-job command:** a load issued during a running job checks that the key registers are locked. A leak would show up as a wrong result on that job or on the next one.
- **Random runs:** randomly chosen operands, moduli and short exponents cover general arithmetic, checked against a reference power function.
- **Long countdown:** a long exponent with a small modulus exercises a full 8-bit countdown.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_SETUP   = 4'd1,
    S_BASE    = 4'd2,
    S_MUL     = 4'd3,
    S_MOD     = 4'd4,
    S_FINISH  = 4'd5,
    S_SETEXP  = 4'd6,
    S_SETMOD  = 4'd7
  } ctrlState_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ENC  = 2'd1,
    CMD_MOD  = 2'd2,
    CMD_EXP  = 2'd3
  } cmdCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic init;
    logic baseSub;
    logic baseCopy;
    logic mult;
    logic modSub;
    logic publish;
    logic loadE;
    logic loadN;
    logic setErr;
    logic clrFlags;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cntEqE;
    logic cntIsOne;
    logic baseGeN;
    logic accGeN;
    logic keyBad;
  } dpStatus_t;

endpackage

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cmdType,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output ctrlState_t  state
);

  ctrlState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        unique case (cmdType)
          CMD_ENC: begin
            if (status.keyBad) begin
              strobe.setErr = 1'b1;
            end else begin
              strobe.capture  = 1'b1;
              strobe.clrFlags = 1'b1;
              stateNext       = S_SETUP;
            end
          end
          CMD_MOD: begin
            strobe.capture  = 1'b1;
            strobe.clrFlags = 1'b1;
            stateNext       = S_SETMOD;
          end
          CMD_EXP: begin
            strobe.capture  = 1'b1;
            strobe.clrFlags = 1'b1;
            stateNext       = S_SETEXP;
          end
          default: stateNext = S_IDLE;
        endcase
      end
      S_SETUP: begin
        strobe.init = 1'b1;
        if (status.cntEqE) stateNext = S_BASE;
      end
      S_BASE: begin
        if (status.baseGeN) begin
          strobe.baseSub = 1'b1;
        end else begin
          strobe.baseCopy = 1'b1;
          stateNext       = S_MUL;
        end
      end
      S_MUL: begin
        if (status.cntIsOne) begin
          stateNext = S_FINISH;
        end else begin
          strobe.mult = 1'b1;
          stateNext   = S_MOD;
        end
      end
      S_MOD: begin
        if (status.accGeN) strobe.modSub = 1'b1;
        else               stateNext     = S_MUL;
      end
      S_FINISH: begin
        strobe.publish = 1'b1;
        stateNext      = S_IDLE;
      end
      S_SETEXP: begin
        strobe.loadE = 1'b1;
        stateNext    = S_IDLE;
      end
      S_SETMOD: begin
        strobe.loadN = 1'b1;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/modexp_dpath.sv
module modexp_dpath
  import modexp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [W-1:0]    dataIn,
  input  ctrlStrobe_t     strobe,
  output dpStatus_t       status,
  output logic [W-1:0]    result,
  output logic            done,
  output logic            error,
  output logic [W-1:0]    modulusVal,
  output logic [W-1:0]    exponentVal,
  output logic [2*W-1:0]  accVal
);

  localparam int AccW = 2 * W;

  logic [W-1:0]    opnd;
  logic [W-1:0]    nReg;
  logic [W-1:0]    eReg;
  logic [W-1:0]    xReg;
  logic [W-1:0]    cnt;
  logic [AccW-1:0] acc;

  // command operand and key registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opnd <= '0;
      nReg <= '0;
      eReg <= '0;
    end else begin
      if (strobe.capture) opnd <= dataIn;
      if (strobe.loadN)   nReg <= opnd;
      if (strobe.loadE)   eReg <= opnd;
    end
  end

  // base, running value and countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      acc  <= '0;
      cnt  <= '0;
    end else begin
      if (strobe.init) begin
        xReg <= opnd;
        acc  <= AccW'(opnd);
        cnt  <= eReg;
      end
      if (strobe.baseSub)  xReg <= xReg - nReg;
      if (strobe.baseCopy) acc  <= AccW'(xReg);
      if (strobe.mult) begin
        acc <= AccW'(acc[W-1:0]) * AccW'(xReg);
        cnt <= cnt - W'(1);
      end
      if (strobe.modSub) acc <= acc - AccW'(nReg);
    end
  end

  // published result and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      if (strobe.clrFlags) begin
        done  <= 1'b0;
        error <= 1'b0;
      end
      if (strobe.setErr) begin
        error <= 1'b1;
        done  <= 1'b0;
      end
      if (strobe.publish) begin
        result <= acc[W-1:0];
        done   <= 1'b1;
      end
    end
  end

  always_comb begin
    status.cntEqE   = (cnt == eReg);
    status.cntIsOne = (cnt == W'(1));
    status.baseGeN  = (xReg >= nReg);
    status.accGeN   = (acc >= AccW'(nReg));
    status.keyBad   = (nReg == '0) || (eReg == '0);
  end

  assign modulusVal  = nReg;
  assign exponentVal = eReg;
  assign accVal      = acc;

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
  import modexp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   cmdType,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] result,
  output logic         done,
  output logic         error
);

  ctrlStrobe_t    strobe;
  dpStatus_t      status;
  ctrlState_t     state;
  logic [W-1:0]   modulusVal;
  logic [W-1:0]   exponentVal;
  logic [2*W-1:0] accVal;

  modexp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdType (cmdType),
    .status  (status),
    .strobe  (strobe),
    .state   (state)
  );

  modexp_dpath #(.W(W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .strobe      (strobe),
    .status      (status),
    .result      (result),
    .done        (done),
    .error       (error),
    .modulusVal  (modulusVal),
    .exponentVal (exponentVal),
    .accVal      (accVal)
  );

endmodule

// File: rtl/modexp_checker.sv
module modexp_checker
  import modexp_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic [1:0]     cmdType,
  input logic           done,
  input logic           error,
  input logic [W-1:0]   result,
  input logic [W-1:0]   modulusVal,
  input logic [W-1:0]   exponentVal,
  input logic [2*W-1:0] accVal,
  input ctrlState_t     state
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R6

  AST_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (result < modulusVal)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable(result)); // R3

  AST_PRODUCT_FITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MUL) |-> (accVal < {{W{1'b0}}, modulusVal})); // R8

  AST_BADKEY_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && (cmdType == 2'd1) &&
     ((modulusVal == '0) || (exponentVal == '0))) |=> (error && !done)); // R6

  AST_KEYS_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ((state != S_IDLE) && (state != S_SETMOD) && (state != S_SETEXP))
      |=> ($stable(modulusVal) && $stable(exponentVal))); // R7

endmodule

bind modexp_engine modexp_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdType     (cmdType),
  .done        (done),
  .error       (error),
  .result      (result),
  .modulusVal  (modulusVal),
  .exponentVal (exponentVal),
  .accVal      (accVal),
  .state       (state)
);

// File: tb/tb_modexp_engine.sv
module tb_modexp_engine;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   cmdType = 2'd0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] result;
  logic         done;
  logic         error;

  int checks = 0;
  int fails  = 0;

  modexp_engine #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .cmdType(cmdType), .dataIn(dataIn),
    .result(result), .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int refPow(input int x, input int e, input int n);
    int base = x % n;
    int r = base;
    for (int i = 1; i < e; i++) r = (r * base) % n;
    return r;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic sendCmd(input logic [1:0] code, input logic [W-1:0] val);
    @(negedge clk);
    cmdType = code;
    dataIn  = val;
    @(negedge clk);
    cmdType = 2'd0;
    dataIn  = $urandom_range(0, 255);
  endtask

  task automatic waitFlag();
    int guard = 0;
    while (!(done || error) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic setKeys(input int n, input int e);
    sendCmd(2'd2, W'(n));
    sendCmd(2'd3, W'(e));
    @(negedge clk);
  endtask

  task automatic encCheck(input string req, input int x, input int e, input int n);
    sendCmd(2'd1, W'(x));
    waitFlag();
    check({req, " done"}, int'(done), 1);
    check({req, " error"}, int'(error), 0);
    check({req, " result"}, int'(result), refPow(x, e, n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int holdRes;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 result", int'(result), 0);
    check("R1 done", int'(done), 0);
    check("R1 error", int'(error), 0);
    sendCmd(2'd1, 8'd5);
    @(negedge clk);
    check("R1 zero keys refused", int'(error), 1);

    // R2, R10: loads accepted, error cleared, code 0 inert
    sendCmd(2'd2, 8'd7);
    check("R10 error cleared", int'(error), 0);
    sendCmd(2'd3, 8'd1);
    sendCmd(2'd0, 8'd99);
    @(negedge clk);
    // R4: e=1 gives x mod n
    encCheck("R4 e1 x>=n", 200, 1, 7);
    encCheck("R2 keys loaded", 3, 1, 7);

    // R3: general exponent, result held while idle
    setKeys(13, 5);
    encCheck("R3 basic", 6, 5, 13);
    holdRes = int'(result);
    repeat (5) @(negedge clk);
    check("R3 held", int'(result), holdRes);
    check("R3 done held", int'(done), 1);

    // R9: keys persist
    encCheck("R9 reuse a", 250, 5, 13);
    encCheck("R9 reuse b", 0, 5, 13);

    // R5: n = 1
    setKeys(1, 9);
    encCheck("R5 n1", 173, 9, 1);

    // R7: command during a job is ignored
    setKeys(251, 10);
    sendCmd(2'd1, 8'd123);
    sendCmd(2'd2, 8'd17);
    sendCmd(2'd3, 8'd2);
    waitFlag();
    check("R7 job result", int'(result), refPow(123, 10, 251));
    encCheck("R7 keys kept", 45, 10, 251);

    // R8: long countdown, small modulus
    setKeys(3, 255);
    encCheck("R8 e255", 254, 255, 3);
    setKeys(255, 2);
    encCheck("R8 max modulus", 254, 2, 255);

    // R6: zero exponent refused, result unchanged
    holdRes = int'(result);
    sendCmd(2'd3, 8'd0);
    sendCmd(2'd1, 8'd9);
    @(negedge clk);
    check("R6 error", int'(error), 1);
    check("R6 done low", int'(done), 0);
    check("R6 result kept", int'(result), holdRes);
    sendCmd(2'd3, 8'd4);
    check("R10 cleared by load", int'(error), 0);
    sendCmd(2'd2, 8'd0);
    sendCmd(2'd1, 8'd9);
    @(negedge clk);
    check("R6 zero modulus error", int'(error), 1);

    // random runs
    for (int k = 0; k < 20; k++) begin
      int n = $urandom_range(1, 255);
      int e = $urandom_range(1, 12);
      int x = $urandom_range(0, 255);
      setKeys(n, e);
      encCheck("R3 random", x, e, n);
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule